// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the unsigned product of two 4-bit operands in four clock steps and presents an 8-bit result. When a start pulse arrives and the unit is idle, it captures both operands, clears its product register and zeroes its step counter. On each step the counter value selects one bit of the stored multiplier. That bit gates every bit of the stored multiplicand. A ripple adder with its carry-in held at zero adds the gated value to the upper half of the product register. The register then moves right by one place. The adder carry enters the top bit, and the lowest sum bit drops into the lower half.

After the fourth step the unit raises a done flag for a single cycle and returns to idle. The product stays on the output until the next accepted start. A start that arrives in the done cycle is accepted, so operations can run back to back every five cycles. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held, and during the cycles after its release, `product_o` reads 0 and `done_o` reads 0.
- R2: A start pulse sampled while the unit is idle captures both operands. After that clock edge, `product_o` reads 0 and `done_o` reads 0.
- R3: Multiplier bits are consumed least significant first, one per step. Step k (k = 0..3) uses multiplier bit k.
- R4: On each step, the gated multiplicand is added to the upper four product bits with a carry-in of 0. The five-bit sum, carry on top, becomes bits 7..3, and the old bits 3..1 become bits 2..0. After step k the output therefore reads (sum over i<=k of a*b[i]*2^i) shifted left by 3-k.
- R5: `done_o` is 1 in exactly one cycle: the fourth cycle after the start edge, when step 3 has completed.
- R6: When `done_o` is 1, `product_o` equals the unsigned product of the captured operands for every operand pair. For example, 10 times 9 gives 8'b01011010.
- R7: A start pulse that arrives while steps are running is ignored. The result still belongs to the operands captured at the accepted start.
- R8: While idle and with no start, `product_o` holds its value, whatever the operand inputs do.
- R9: A start sampled in the cycle where `done_o` is 1 is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside |
| start | input | 1 | Begins an operation when the unit is idle |
| mcand_i | input | 4 | Multiplicand, unsigned |
| mplier_i | input | 4 | Multiplier, unsigned |
| product_o | output | 8 | Product register contents |
| done_o | output | 1 | One-cycle flag: result is final |

## Verification
The product register is visible at the port on every step, so each cycle is checked against the partial sum that R4 predicts. A wrong bit pick, a lost carry or a shift by the wrong amount therefore shows on the first faulty step, not only in the final result. A counter that fails to wrap, or a busy state that never clears, moves or loses the done pulse within five cycles of the start. A start that gets through while steps are running corrupts the next partial product that is checked.

// File: rtl/msa_pkg.sv
package msa_pkg;
  // Operand width used by default across the block.
  localparam int unsigned OPW_DEF = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } msa_state_e;
endpackage

// File: rtl/msa_rst_sync.sv
module msa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/msa_step_ctr.sv
module msa_step_ctr #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] LAST_VAL = CW'(STEPS - 1);

  logic [CW-1:0] cnt_d;

  assign last = (cnt == LAST_VAL);

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = last ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || adv) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/msa_bit_pick.sv
module msa_bit_pick #(
  parameter int unsigned OPW = 4,
  localparam int unsigned SW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic [OPW-1:0] word,
  input  logic [SW-1:0]  sel,
  output logic           bit_o
);
  logic [OPW-1:0] hit;

  for (genvar g = 0; g < OPW; g++) begin : g_leg
    assign hit[g] = word[g] & (sel == SW'(g));
  end

  assign bit_o = |hit;
endmodule

// File: rtl/msa_gated_add.sv
module msa_gated_add #(
  parameter int unsigned OPW = 4
) (
  input  logic [OPW-1:0] mcand,
  input  logic           gate,
  input  logic [OPW-1:0] acc,
  output logic [OPW:0]   sum
);
  localparam logic CIN = 1'b0;

  logic [OPW-1:0] gated;
  logic [OPW:0]   carry;

  for (genvar g = 0; g < OPW; g++) begin : g_and
    assign gated[g] = mcand[g] & gate;
  end

  assign carry[0] = CIN;
  for (genvar g = 0; g < OPW; g++) begin : g_fa
    assign sum[g]     = acc[g] ^ gated[g] ^ carry[g];
    assign carry[g+1] = (acc[g] & gated[g]) | (carry[g] & (acc[g] ^ gated[g]));
  end
  assign sum[OPW] = carry[OPW];
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned OPW = msa_pkg::OPW_DEF,
  localparam int unsigned PW = 2 * OPW,
  localparam int unsigned CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [OPW-1:0] mcand_i,
  input  logic [OPW-1:0] mplier_i,
  output logic [PW-1:0]  product_o,
  output logic           done_o
);
  import msa_pkg::*;

  logic             rst_sync_n;
  msa_state_e       state_q, state_d;
  logic [OPW-1:0]   mcand_q, mplier_q;
  logic [PW-1:0]    prod_q, prod_d;
  logic             done_q, done_d;
  logic             busy;
  logic             accept;
  logic             step;
  logic             last;
  logic [CW-1:0]    cnt;
  logic             pick;
  logic [OPW:0]     sum;

  msa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign busy   = (state_q == ST_RUN);
  assign accept = start & ~busy;
  assign step   = busy;

  msa_step_ctr #(.STEPS(OPW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (accept),
    .adv   (step),
    .cnt   (cnt),
    .last  (last)
  );

  msa_bit_pick #(.OPW(OPW)) u_pick (
    .word  (mplier_q),
    .sel   (cnt),
    .bit_o (pick)
  );

  msa_gated_add #(.OPW(OPW)) u_add (
    .mcand (mcand_q),
    .gate  (pick),
    .acc   (prod_q[PW-1:OPW]),
    .sum   (sum)
  );

  always_comb begin
    state_d = state_q;
    prod_d  = prod_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      prod_d  = '0;
    end else if (step) begin
      prod_d = {sum, prod_q[OPW-1:1]};
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // Operand capture, enabled only by an accepted start.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (accept) begin
      mcand_q  <= mcand_i;
      mplier_q <= mplier_i;
    end
  end

  // Product register, enabled on capture or on a step.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prod_q <= '0;
    end else if (accept || step) begin
      prod_q <= prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign product_o = prod_q;
  assign done_o    = done_q;
endmodule

// File: rtl/msa_checker.sv
module msa_checker #(
  parameter int unsigned OPW = 4,
  localparam int unsigned PW = 2 * OPW,
  localparam int unsigned CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input logic           clk,
  input logic           rst_ok_n,
  input logic           start,
  input logic           busy,
  input logic           accept,
  input logic [CW-1:0]  cnt,
  input logic [OPW-1:0] mcand_q,
  input logic [OPW-1:0] mplier_q,
  input logic [PW-1:0]  product,
  input logic           done
);
  // R2: after an accepted start the product is clear, the counter is zero and steps run.
  a_r2_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_ok_n)
    accept |=> (product == '0) && (cnt == '0) && busy);

  // R5: done lasts a single cycle.
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |=> !done);

  // R6: the final value matches the captured operands.
  a_r6_product_on_done: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |-> (product == (PW'(mcand_q) * PW'(mplier_q))));

  // R5: the counter has wrapped back to zero when the result is final.
  a_r5_cnt_wrapped: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |-> (cnt == '0) && !busy);

  // R7: a start during steps leaves the captured operands alone.
  a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (busy && start) |=> $stable(mcand_q) && $stable(mplier_q));

  // R8: idle with no start keeps the product.
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind shift_add_mul msa_checker #(.OPW(OPW)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .start    (start),
  .busy     (busy),
  .accept   (accept),
  .cnt      (cnt),
  .mcand_q  (mcand_q),
  .mplier_q (mplier_q),
  .product  (product_o),
  .done     (done_o)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] mcand_i;
  logic [3:0] mplier_i;
  logic [7:0] product_o;
  logic       done_o;

  int checks;
  int errors;
  int cyc;

  shift_add_mul u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Partial product after step k, placed as R4 describes.
  function automatic logic [7:0] exp_part(input logic [3:0] a, input logic [3:0] b, input int k);
    logic [7:0] p;
    p = '0;
    for (int i = 0; i <= k; i++) begin
      if (b[i]) p = p + (8'(a) << i);
    end
    return p << (3 - k);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where done is high.
  task automatic run_op(input logic [3:0] a, input logic [3:0] b, input bit intrude);
    start    = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start = 1'b0;
    chk(product_o == 8'd0, "R2/R9 product cleared", product_o, 0);
    chk(done_o == 1'b0, "R2 done low after start", done_o, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (intrude && k == 2) start = 1'b0;
      chk(product_o == exp_part(a, b, k), "R3/R4 partial product", product_o, exp_part(a, b, k));
      chk(done_o == (k == 3), "R5 done timing", done_o, (k == 3) ? 1 : 0);
      if (intrude && k == 0) begin
        start    = 1'b1;
        mcand_i  = 4'($urandom());
        mplier_i = 4'($urandom());
      end
    end
    chk(product_o == 8'(a) * 8'(b), "R6 final product", product_o, 8'(a) * 8'(b));
  endtask

  initial begin
    logic [3:0] ra, rb;
    logic [7:0] held;
    int unsigned seed_val;
    checks   = 0;
    errors   = 0;
    cyc      = 0;
    seed_val = $urandom(32'd2718);
    rst_n    = 1'b0;
    start    = 1'b0;
    mcand_i  = 4'd0;
    mplier_i = 4'd0;
    repeat (3) @(negedge clk);
    chk(product_o == 8'd0, "R1 product in reset", product_o, 0);
    chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(product_o == 8'd0, "R1 product after release", product_o, 0);
    chk(done_o == 1'b0, "R1 done after release", done_o, 0);

    // Directed: 10 x 9, then hold checks while idle with moving inputs (R8).
    run_op(4'd10, 4'd9, 1'b0);
    chk(product_o == 8'b01011010, "R6 ten times nine", product_o, 90);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done drops", done_o, 0);
    for (int i = 0; i < 4; i++) begin
      mcand_i  = 4'($urandom());
      mplier_i = 4'($urandom());
      @(negedge clk);
      chk(product_o == 8'd90, "R8 product held while idle", product_o, 90);
    end

    // Corner cases.
    run_op(4'd15, 4'd15, 1'b0);
    run_op(4'd0, 4'd15, 1'b0);
    run_op(4'd15, 4'd0, 1'b0);
    run_op(4'd15, 4'd8, 1'b0);

    // All operand pairs, chained back to back (R9: start in the done cycle).
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(4'(a), 4'(b), 1'b0);
      end
    end
    @(negedge clk);

    // Random pairs with a start pulse injected mid-run (R7).
    for (int n = 0; n < 200; n++) begin
      ra = 4'($urandom());
      rb = 4'($urandom());
      run_op(ra, rb, 1'b1);
      held = product_o;
      @(negedge clk);
      chk(product_o == held, "R7 stray start ignored, result held", product_o, held);
      chk(done_o == 1'b0, "R7 no extra operation", done_o, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule